// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block lets synchronous logic use an external asynchronous static RAM with a 16-bit data bus, a 19-bit word address and separate enables for the upper and lower byte. A client raises a request with the direction, the address, the write data and a two-bit byte mask. The block returns a one-cycle acknowledge; read data comes with that acknowledge.

The memory has no clock, so the block meets its timing by counting clock cycles. Each nanosecond minimum (read cycle, output-enable-to-data, write-enable pulse, data setup, write cycle and output release) is a parameter. It is rounded up to whole cycles of the `CLK_NS` clock period. After reset the block holds off every access for a power-up interval, which is 200 µs by default.

All memory-side pins come from flops, so they do not glitch. The data bus is split into an output word, an input word and one output-enable for an external tri-state buffer.

Top module: `sram_bridge`

## Requirements
- R1: After reset is released, `busy` stays high and every memory enable pin stays inactive for PWR_CYC = ceil(200000 ns / CLK_NS) cycles (20000 by default). A request made during that interval is dropped and never reaches the memory.
- R2: A read holds `sram_ce_n`, `sram_oe_n` and the selected byte enables low for RD_CYC = ceil(max(45, 22) ns / CLK_NS) cycles (5 by default). It samples `dq_in` on the last of those edges. `ack` rises 7 cycles after the accepting edge at the default timing.
- R3: Mask bit 0 selects the lower lane, `dq[7:0]`, on `sram_lb_n`. Mask bit 1 selects the upper lane, `dq[15:8]`, on `sram_ub_n`. On a read, lanes that are not selected come back as zero in `rdata`. On a write, the memory keeps its old contents in those lanes.
- R4: A write spends one setup cycle with the data driven and the write enable high. The write enable is then low for WE_CYC = ceil(max(35, 25) ns / CLK_NS) cycles (4 by default). A recovery cycle follows, so the whole cycle lasts at least ceil(45 ns / CLK_NS) cycles. `ack` rises 6 cycles after the accepting edge at the default timing.
- R5: `sram_we_n` is high during reads and `sram_oe_n` is high during writes and idle. The two are never low together. `dq_oe` is high only in the write setup and write-enable states, and it is high whenever the write enable is low.
- R6: After `sram_oe_n` rises, at least TURN_CYC = ceil(18 ns / CLK_NS) cycles (2 by default) pass before `dq_oe` rises.
- R7: A request with a zero mask is acknowledged on the next cycle. No memory pin moves and the memory contents stay the same.
- R8: `ack` is high for exactly one cycle. `busy` is high from the accepting edge until the acknowledge. A request presented while `busy` is high is dropped.
- R9: `sram_addr` does not change while `sram_ce_n` stays low. The address and write data are registered when the request is accepted.
- R10: While reset is high, `busy` is high, `ack` and `dq_oe` are low, and every active-low memory pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when `busy` is low |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select, bit 1 upper, bit 0 lower |
| busy | output | 1 | Block cannot take a request |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with `ack` |
| sram_addr | output | 19 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| dq_out | output | 16 | Data toward the memory |
| dq_in | input | 16 | Data from the memory |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
If the cycle counter or the state register holds a wrong value, the acknowledge comes at a different cycle, so the latency checks catch it on that same request. Because the memory model in the bench returns a marker word until the output enable has been low long enough, a read window that is one cycle short shows up as corrupt data. A wrong pin decode shows up within one cycle: the model records an overlap of write and output enable, an undriven bus during a write, a write pulse of the wrong width, or an address that moves during a write. A lane mix-up shows up on the next read of that word.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_RACT,
    ST_RREC,
    ST_WSET,
    ST_WACT,
    ST_WREC
  } st_t;

  // whole clock cycles that cover a nanosecond minimum
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bridge_timer.sv
module sram_bridge_timer #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= RST_VAL;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst) load |=> (cnt == $past(load_val))); // R2

endmodule

// File: rtl/sram_bridge_lanes.sv
module sram_bridge_lanes #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANE_W = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        rdata[g*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rdata[g*LANE_W +: LANE_W] <= mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end
  end

endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int CLK_NS     = 10,
  parameter int T_RC_NS    = 45,
  parameter int T_DOE_NS   = 22,
  parameter int T_WC_NS    = 45,
  parameter int T_PWE_NS   = 35,
  parameter int T_SD_NS    = 25,
  parameter int T_HZOE_NS  = 18,
  parameter int T_PWRUP_NS = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_mask,
  output logic              busy,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] dq_out,
  input  logic [DATA_W-1:0] dq_in,
  output logic              dq_oe
);

  localparam int RD_CYC   = imax(1, imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS)));
  localparam int WE_CYC   = imax(1, imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)));
  localparam int WR_CYC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int WREC_CYC = imax(1, WR_CYC - 1 - WE_CYC);
  localparam int TURN_CYC = imax(1, ns_to_cyc(T_HZOE_NS, CLK_NS));
  localparam int PWR_CYC  = imax(1, ns_to_cyc(T_PWRUP_NS, CLK_NS));
  localparam int MAX_CYC  = imax(imax(RD_CYC, WE_CYC), imax(imax(WREC_CYC, TURN_CYC), PWR_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1) + 1;
  localparam int MON_W    = $clog2(imax(WE_CYC, TURN_CYC) + 2) + 1;

  localparam logic [CNT_W-1:0] LD_PWR  = CNT_W'(PWR_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WE   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WREC = CNT_W'(WREC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);
  localparam logic [MON_W-1:0] WE_LIM   = MON_W'(WE_CYC);
  localparam logic [MON_W-1:0] TURN_LIM = MON_W'(TURN_CYC);

  st_t               st, st_n;
  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;
  logic              accept, ack_n, cap;
  logic [1:0]        mask_q, mask_n;
  logic              act_n;

  sram_bridge_timer #(.CNT_W(CNT_W), .RST_VAL(LD_PWR)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  sram_bridge_lanes #(.DATA_W(DATA_W), .LANES(2)) u_lanes (
    .clk     (clk),
    .rst     (rst),
    .capture (cap),
    .mask    (mask_q),
    .dq_in   (dq_in),
    .rdata   (rdata)
  );

  // next-state decode
  always_comb begin
    st_n   = st;
    t_load = 1'b0;
    t_val  = '0;
    accept = 1'b0;
    ack_n  = 1'b0;
    cap    = 1'b0;
    unique case (st)
      ST_INIT: if (t_zero) st_n = ST_IDLE;
      ST_IDLE: begin
        if (req) begin
          if (req_mask == 2'b00) begin
            ack_n = 1'b1;
          end else begin
            accept = 1'b1;
            if (req_wr) begin
              st_n = ST_WSET;
            end else begin
              st_n   = ST_RACT;
              t_load = 1'b1;
              t_val  = LD_RD;
            end
          end
        end
      end
      ST_RACT: if (t_zero) begin
        st_n   = ST_RREC;
        cap    = 1'b1;
        t_load = 1'b1;
        t_val  = LD_TURN;
      end
      ST_RREC: if (t_zero) begin
        st_n  = ST_IDLE;
        ack_n = 1'b1;
      end
      ST_WSET: begin
        st_n   = ST_WACT;
        t_load = 1'b1;
        t_val  = LD_WE;
      end
      ST_WACT: if (t_zero) begin
        st_n   = ST_WREC;
        t_load = 1'b1;
        t_val  = LD_WREC;
      end
      ST_WREC: if (t_zero) begin
        st_n  = ST_IDLE;
        ack_n = 1'b1;
      end
      default: st_n = ST_INIT;
    endcase
  end

  assign mask_n = accept ? req_mask : mask_q;
  assign act_n  = (st_n == ST_RACT) || (st_n == ST_WSET) || (st_n == ST_WACT);

  // state and registered pins
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_INIT;
      busy      <= 1'b1;
      ack       <= 1'b0;
      mask_q    <= 2'b00;
      sram_addr <= '0;
      dq_out    <= '0;
      sram_ce_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_ub_n <= 1'b1;
      sram_lb_n <= 1'b1;
      dq_oe     <= 1'b0;
    end else begin
      st        <= st_n;
      busy      <= (st_n != ST_IDLE);
      ack       <= ack_n;
      mask_q    <= mask_n;
      if (accept) begin
        sram_addr <= req_addr;
        dq_out    <= req_wdata;
      end
      sram_ce_n <= !act_n;
      sram_we_n <= !(st_n == ST_WACT);
      sram_oe_n <= !(st_n == ST_RACT);
      sram_ub_n <= !(act_n && mask_n[1]);
      sram_lb_n <= !(act_n && mask_n[0]);
      dq_oe     <= (st_n == ST_WSET) || (st_n == ST_WACT);
    end
  end

  // pulse-width monitors for the assertions below
  logic [MON_W-1:0] we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      oe_hi_cnt <= TURN_LIM;
    end else begin
      if (!sram_we_n) begin
        if (we_lo_cnt != '1) we_lo_cnt <= we_lo_cnt + 1'b1;
      end else begin
        we_lo_cnt <= '0;
      end
      if (sram_oe_n) begin
        if (oe_hi_cnt != '1) oe_hi_cnt <= oe_hi_cnt + 1'b1;
      end else begin
        oe_hi_cnt <= '0;
      end
    end
  end

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (rst) (st == ST_INIT) |-> (busy && sram_ce_n && !ack)); // R1
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(sram_we_n) |-> (we_lo_cnt >= WE_LIM)); // R4
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!sram_we_n && !sram_oe_n)); // R5
  AST_BUS_OE_HIGH: assert property (@(posedge clk) disable iff (rst) dq_oe |-> sram_oe_n); // R5
  AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (rst) !sram_we_n |-> dq_oe); // R5
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst) $rose(dq_oe) |-> (oe_hi_cnt >= TURN_LIM)); // R6
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (rst) (st == ST_IDLE && req && req_mask == 2'b00) |=> (ack && sram_ce_n)); // R7
  AST_ACK_ONE: assert property (@(posedge clk) disable iff (rst) ack |=> !ack); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr)); // R9

endmodule

// File: tb/sram_bridge_bench.sv
module sram_bridge_bench;

  localparam int PWR = 20000;

  typedef struct packed {
    logic        wr;
    logic [1:0]  mask;
    logic [18:0] addr;
    logic [15:0] data;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b11, 19'h00001, 16'h1234, 4'd6},
    '{1'b0, 2'b11, 19'h00001, 16'h0000, 4'd7},
    '{1'b1, 2'b01, 19'h00001, 16'h00AB, 4'd6},
    '{1'b0, 2'b11, 19'h00001, 16'h0000, 4'd7},
    '{1'b1, 2'b11, 19'h40002, 16'hCDEF, 4'd6},
    '{1'b0, 2'b01, 19'h40002, 16'h0000, 4'd7},
    '{1'b0, 2'b10, 19'h40002, 16'h0000, 4'd7},
    '{1'b1, 2'b10, 19'h00002, 16'h7700, 4'd6},
    '{1'b0, 2'b11, 19'h00002, 16'h0000, 4'd7},
    '{1'b1, 2'b00, 19'h00001, 16'hFFFF, 4'd0},
    '{1'b0, 2'b11, 19'h00001, 16'h0000, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, req_wr = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        busy, ack;
  logic [15:0] rdata, dq_out, dq_in;
  logic [18:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, dq_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sram_bridge u_sram_bridge (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .busy(busy), .ack(ack),
    .rdata(rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n),
    .sram_lb_n(sram_lb_n), .dq_out(dq_out), .dq_in(dq_in), .dq_oe(dq_oe)
  );

  // memory model
  logic [15:0] mem [16];
  logic [15:0] ref_m [16];
  int rd_lo = 0, we_lo = 0, oe_hi = 100, ce_lo_total = 0;
  int we_viol = 0, excl_viol = 0, bus_viol = 0, gap_viol = 0, addr_viol = 0, init_viol = 0;
  bit in_init = 0;
  logic prev_ce_n = 1'b1, prev_dq_oe = 1'b0;
  logic [18:0] prev_addr = '0;

  function automatic int idx(input logic [18:0] a);
    return int'({a[18], a[2:0]});
  endfunction

  assign dq_in = (!sram_ce_n && !sram_oe_n && rd_lo >= 5) ? mem[idx(sram_addr)] : 16'hBAD0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = '0;
      ref_m[i] = '0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (!sram_ce_n) ce_lo_total++;
      if (in_init && !sram_ce_n) init_viol++;
      if (!sram_we_n && !sram_oe_n) excl_viol++;
      if ((dq_oe && !sram_oe_n) || (!sram_we_n && !dq_oe)) bus_viol++;
      if (dq_oe && !prev_dq_oe && oe_hi < 2) gap_viol++;
      if (sram_oe_n) oe_hi++; else oe_hi = 0;
      if (!sram_ce_n && !prev_ce_n && sram_addr != prev_addr) addr_viol++;
      if (!sram_we_n) we_lo++;
      else begin
        if (we_lo != 0 && we_lo != 4) we_viol++;
        we_lo = 0;
      end
      if (!sram_ce_n && !sram_oe_n) rd_lo++; else rd_lo = 0;
      if (!sram_ce_n && !sram_we_n) begin
        if (!sram_lb_n) mem[idx(sram_addr)][7:0]  = dq_out[7:0];
        if (!sram_ub_n) mem[idx(sram_addr)][15:8] = dq_out[15:8];
      end
      prev_ce_n  = sram_ce_n;
      prev_dq_oe = dq_oe;
      prev_addr  = sram_addr;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] m, output int lat, output logic [15:0] rd);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    while (!ack && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int lat;
    logic [15:0] rd, e;
    int snap;

    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10 reset busy", busy, 1);
    check("R10 reset ack", ack, 0);
    check("R10 reset pins", {sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, dq_oe}, 6'b111110);

    // R1 power-up wait, request during it is dropped
    rst = 1'b0;
    in_init = 1;
    for (int k = 1; k <= PWR; k++) begin
      @(negedge clk);
      req = (k == 100);
      req_wr = 1'b1; req_addr = 19'h00003; req_wdata = 16'h5555; req_mask = 2'b11;
      if (k == PWR - 1) check("R1 busy before end of wait", busy, 1);
    end
    req = 1'b0;
    in_init = 0;
    check("R1 busy released after wait", busy, 0);
    check("R1 no pin activity during wait", init_viol, 0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v].wr, VEC[v].addr, VEC[v].data, VEC[v].mask, lat, rd);
      if (VEC[v].mask == 2'b00) begin
        check("R7 zero-mask ack latency", lat, 0);
      end else if (VEC[v].wr) begin
        check("R4 write ack latency", lat, VEC[v].lat);
        if (VEC[v].mask[0]) ref_m[idx(VEC[v].addr)][7:0]  = VEC[v].data[7:0];
        if (VEC[v].mask[1]) ref_m[idx(VEC[v].addr)][15:8] = VEC[v].data[15:8];
      end else begin
        check("R2 read ack latency", lat, VEC[v].lat);
        e = ref_m[idx(VEC[v].addr)];
        e = {VEC[v].mask[1] ? e[15:8] : 8'h00, VEC[v].mask[0] ? e[7:0] : 8'h00};
        check("R3 read data by lane", rd, e);
      end
      @(negedge clk);
      check("R8 ack one cycle", ack, 0);
    end

    // R1 request during wait never landed
    do_op(1'b0, 19'h00003, 16'h0, 2'b11, lat, rd);
    check("R1 dropped request left memory", rd, 16'h0000);

    // R7 zero-mask read touches no pin
    snap = ce_lo_total;
    do_op(1'b0, 19'h00001, 16'h0, 2'b00, lat, rd);
    check("R7 zero-mask latency", lat, 0);
    check("R7 no chip enable during zero mask", ce_lo_total - snap, 0);

    // R8 request while busy is dropped
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_addr = 19'h00001; req_mask = 2'b11;
    @(negedge clk);
    req = 1'b0;
    check("R8 busy after accept", busy, 1);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; req_wdata = 16'hFFFF;
    @(negedge clk);
    req = 1'b0;
    lat = 2;
    while (!ack && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R8 latency unaffected by busy request", lat, 7);
    check("R8 read data", rdata, ref_m[1]);
    repeat (3) @(negedge clk);
    check("R8 no late acceptance", {busy, sram_ce_n}, 2'b01);
    do_op(1'b0, 19'h00001, 16'h0, 2'b11, lat, rd);
    check("R8 memory unchanged by dropped write", rd, ref_m[1]);

    // R6 read immediately followed by write
    do_op(1'b0, 19'h40002, 16'h0, 2'b11, lat, rd);
    do_op(1'b1, 19'h40002, 16'h1357, 2'b11, lat, rd);
    ref_m[idx(19'h40002)] = 16'h1357;
    do_op(1'b0, 19'h40002, 16'h0, 2'b11, lat, rd);
    check("R4 write after read", rd, 16'h1357);

    repeat (2) @(negedge clk);
    check("R4 write-enable width", we_viol, 0);
    check("R5 write/output enable overlap", excl_viol, 0);
    check("R5 data bus drive", bus_viol, 0);
    check("R6 turnaround gap", gap_viol, 0);
    check("R9 address stable while selected", addr_viol, 0);
    finish_run();
  end

endmodule